// File: doc/BRIEF.md
# Bidirectional One-Hot Row Scanner

This block is the logic half of a symmetric display row driver. It holds a shift register with one bit per row output. A start pulse clears the register and places a single one at the entry end. Each rising clock edge then moves that one a single place toward the exit end, so the rows are selected one at a time. A direction input sets which end is the entry. It also sets which of two shared pins is the serial input and which is the cascade output, so that several devices can be chained in either scan order.

Each row output is a tri-state drive, given here as an enable and a level. A row is driven only while its register bit is set. It goes to the high rail or to the low rail according to a polarity input, and it is released otherwise. A blanking input releases every row at once and leaves the register as it is. When the token leaves the exit stage, the cascade pin carries it for one clock to the next device in the chain.

Top module: `row_scan_driver`

## Requirements
- R1: Start is sampled on the rising edge. When it is high, the register is cleared and a single one is loaded at the entry end: bit 0 when dir=1, bit ROWS-1 when dir=0. This happens whatever the register held and whatever the serial input is.
- R2: On each rising edge with start low, the register moves one place. With dir=1 it moves toward higher index and bit 0 takes the level on side_a. With dir=0 it moves toward lower index and bit ROWS-1 takes the level on side_b. A change of dir takes effect on the next edge.
- R3: With dir=1, side_b is driven with the cascade bit and side_a is released. With dir=0, side_a is driven and side_b is released.
- R4: row_oe[i] is 1 exactly when register bit i is set and blank is 0. row_lvl[i] is 0 when row_oe[i] is 0.
- R5: A driven row has row_lvl=1 (high rail) when pol=1 and row_lvl=0 (low rail) when pol=0.
- R6: blank=1 forces row_oe to all zeros. The register keeps shifting, so the token shows at its advanced position once blank falls.
- R7: On the edge that shifts a one out of the exit stage (bit ROWS-1 for dir=1, bit 0 for dir=0), the cascade pin goes high for one clock. The vacated register is then all zeros.
- R8: An edge that samples start high clears the cascade bit, even when the token sits in the exit stage.
- R9: rst_n low clears the register and the cascade bit at once. Its release is synchronised, and the register is first updated on the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear register and inject token |
| dir | input | 1 | Scan direction, 1 = toward higher index |
| pol | input | 1 | Rail select for driven rows, 1 = high |
| blank | input | 1 | 1 = release all rows |
| side_a | inout | 1 | Serial input when dir=1, cascade output when dir=0 |
| side_b | inout | 1 | Cascade output when dir=1, serial input when dir=0 |
| row_oe | output | ROWS | Per-row drive enable (0 = high impedance) |
| row_lvl | output | ROWS | Per-row drive level when enabled |

## Verification
Start can land in the same cycle as a one on the serial input. It can also land in the cycle in which the token sits in the exit stage and would otherwise move onto the cascade pin. The bench provokes the first case by driving the input-side pin high while start is asserted with a token already in the register. It provokes the second by walking a token to the last stage and then pulsing start. In both cases it expects a lone one at the entry end and a low cascade pin after the edge, because start takes precedence.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic {
    SCAN_DOWN = 1'b0,
    SCAN_UP   = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/rsd_reset_sync.sv
module rsd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/rsd_shift_core.sv
module rsd_shift_core
  import row_scan_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  scan_dir_e       dir,
  input  logic            ser_in,
  output logic [ROWS-1:0] sr_q,
  output logic            casc_q
);
  localparam logic [ROWS-1:0] ENTRY_UP   = ROWS'(1);
  localparam logic [ROWS-1:0] ENTRY_DOWN = ENTRY_UP << (ROWS - 1);

  logic [ROWS-1:0] sr_d;
  logic            casc_d;
  logic            sr_en;

  assign sr_en = 1'b1;

  always_comb begin
    if (start) begin
      sr_d   = (dir == SCAN_UP) ? ENTRY_UP : ENTRY_DOWN;
      casc_d = 1'b0;
    end else if (dir == SCAN_UP) begin
      sr_d   = {sr_q[ROWS-2:0], ser_in};
      casc_d = sr_q[ROWS-1];
    end else begin
      sr_d   = {ser_in, sr_q[ROWS-1:1]};
      casc_d = sr_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      casc_q <= 1'b0;
    end else if (sr_en) begin
      sr_q   <= sr_d;
      casc_q <= casc_d;
    end
  end
endmodule

// File: rtl/rsd_pin_mux.sv
module rsd_pin_mux
  import row_scan_pkg::*;
(
  input  scan_dir_e dir,
  input  logic      side_a_in,
  input  logic      side_b_in,
  output logic      ser_in,
  output logic      a_oe,
  output logic      b_oe
);
  always_comb begin
    if (dir == SCAN_UP) begin
      ser_in = side_a_in;
      a_oe   = 1'b0;
      b_oe   = 1'b1;
    end else begin
      ser_in = side_b_in;
      a_oe   = 1'b1;
      b_oe   = 1'b0;
    end
  end
endmodule

// File: rtl/rsd_row_stage.sv
module rsd_row_stage #(
  parameter int ROWS = 8
) (
  input  logic [ROWS-1:0] sr_q,
  input  logic            pol,
  input  logic            blank,
  output logic [ROWS-1:0] row_oe,
  output logic [ROWS-1:0] row_lvl
);
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic sel;
    assign sel        = sr_q[i] & ~blank;
    assign row_oe[i]  = sel;
    assign row_lvl[i] = sel & pol;
  end
endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver
  import row_scan_pkg::*;
#(
  parameter int ROWS       = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dir,
  input  logic            pol,
  input  logic            blank,
  inout  wire             side_a,
  inout  wire             side_b,
  output logic [ROWS-1:0] row_oe,
  output logic [ROWS-1:0] row_lvl
);
  logic            rst_core_n;
  logic [ROWS-1:0] sr_q;
  logic            casc_q;
  logic            ser_in;
  logic            a_oe;
  logic            b_oe;
  scan_dir_e       dir_e;

  assign dir_e = scan_dir_e'(dir);

  rsd_reset_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  rsd_pin_mux u_pins (
    .dir       (dir_e),
    .side_a_in (side_a),
    .side_b_in (side_b),
    .ser_in    (ser_in),
    .a_oe      (a_oe),
    .b_oe      (b_oe)
  );

  rsd_shift_core #(.ROWS(ROWS)) u_core (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .start  (start),
    .dir    (dir_e),
    .ser_in (ser_in),
    .sr_q   (sr_q),
    .casc_q (casc_q)
  );

  rsd_row_stage #(.ROWS(ROWS)) u_rows (
    .sr_q    (sr_q),
    .pol     (pol),
    .blank   (blank),
    .row_oe  (row_oe),
    .row_lvl (row_lvl)
  );

  assign side_a = a_oe ? casc_q : 1'bz;
  assign side_b = b_oe ? casc_q : 1'bz;
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int ROWS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_core_n,
  input logic            start,
  input logic            dir,
  input logic            pol,
  input logic            blank,
  input logic [ROWS-1:0] sr_q,
  input logic            casc_q,
  input logic            a_oe,
  input logic            b_oe,
  input logic [ROWS-1:0] row_oe,
  input logic [ROWS-1:0] row_lvl
);
  localparam logic [ROWS-1:0] TOP_BIT = ROWS'(1) << (ROWS - 1);

  AST_START_UP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (start && dir) |=> (sr_q == ROWS'(1)));  // R1
  AST_START_DOWN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (start && !dir) |=> (sr_q == TOP_BIT));  // R1
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!start && dir) |=> (sr_q[ROWS-1:1] == $past(sr_q[ROWS-2:0])));  // R2
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!start && !dir) |=> (sr_q[ROWS-2:0] == $past(sr_q[ROWS-1:1])));  // R2
  AST_ONE_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({a_oe, b_oe}) == 1) && (b_oe == dir));  // R3
  AST_NO_STRAY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_oe & ~sr_q) == '0));  // R4
  AST_RAIL_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (row_lvl == (row_oe & {ROWS{pol}})));  // R5
  AST_BLANK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (row_oe == '0));  // R6
  AST_CASC_EXIT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!start && (dir ? sr_q[ROWS-1] : sr_q[0])) |=> casc_q);  // R7
  AST_START_CLEARS_CASC: assert property (@(posedge clk) disable iff (!rst_core_n)
    start |=> !casc_q);  // R8
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_core_n |-> ((sr_q == '0) && !casc_q));  // R9
endmodule

bind row_scan_driver rsd_checker #(.ROWS(ROWS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_core_n (rst_core_n),
  .start      (start),
  .dir        (dir),
  .pol        (pol),
  .blank      (blank),
  .sr_q       (sr_q),
  .casc_q     (casc_q),
  .a_oe       (a_oe),
  .b_oe       (b_oe),
  .row_oe     (row_oe),
  .row_lvl    (row_lvl)
);

// File: tb/row_scan_driver_tb_top.sv
module row_scan_driver_tb_top;
  localparam int ROWS = 8;
  localparam int NVEC = 14;
  localparam int WDOG_CYCLES = 200000;

  logic clk, rst_n, start, dir, pol, blank;
  logic drv_a, drv_b, a_val, b_val;
  wire  side_a, side_b;
  logic [ROWS-1:0] row_oe, row_lvl;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  assign side_a = drv_a ? a_val : 1'bz;
  assign side_b = drv_b ? b_val : 1'bz;

  row_scan_driver #(.ROWS(ROWS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .pol(pol),
    .blank(blank), .side_a(side_a), .side_b(side_b),
    .row_oe(row_oe), .row_lvl(row_lvl)
  );

  // {start,dir,pol,blank,ser} , expected row_oe , expected row_lvl , expected cascade
  localparam logic [21:0] VECS [0:NVEC-1] = '{
    {5'b11100, 8'h01, 8'h01, 1'b0},  // R1 start up
    {5'b01100, 8'h02, 8'h02, 1'b0},  // R2
    {5'b01000, 8'h04, 8'h00, 1'b0},  // R5 low rail
    {5'b01110, 8'h00, 8'h00, 1'b0},  // R6 blank
    {5'b01100, 8'h10, 8'h10, 1'b0},  // R6 kept walking
    {5'b01101, 8'h21, 8'h21, 1'b0},  // R2 serial in on side_a
    {5'b01100, 8'h42, 8'h42, 1'b0},
    {5'b01100, 8'h84, 8'h84, 1'b0},
    {5'b01100, 8'h08, 8'h08, 1'b1},  // R7 exit on side_b
    {5'b01100, 8'h10, 8'h10, 1'b0},  // R7 one clock only
    {5'b10100, 8'h80, 8'h80, 1'b0},  // R1 start down
    {5'b00100, 8'h40, 8'h40, 1'b0},  // R2 down
    {5'b00101, 8'hA0, 8'hA0, 1'b0},  // R2 serial in on side_b
    {5'b11101, 8'h01, 8'h01, 1'b0}   // R1 start beats serial one
  };

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic d, input logic p, input logic b, input logic ser);
    start = s; dir = d; pol = p; blank = b;
    drv_a = d;  a_val = d ? ser : 1'b0;
    drv_b = !d; b_val = d ? 1'b0 : ser;
  endtask

  function automatic logic casc_pin();
    return dir ? side_b : side_a;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(WDOG_CYCLES * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    #3;
    chk("R9 reset rows", 32'(row_oe), 32'h0);
    chk("R9 reset cascade", 32'(casc_pin()), 32'h0);
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    chk("R9 idle after release", 32'(row_oe), 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [21:0] e;
      e = VECS[v];
      apply(e[21], e[20], e[19], e[18], e[17]);
      step();
      chk($sformatf("R1/R2/R4 vec%0d row_oe", v), 32'(row_oe), 32'(e[16:9]));
      chk($sformatf("R5 vec%0d row_lvl", v), 32'(row_lvl), 32'(e[8:1]));
      chk($sformatf("R7/R3 vec%0d cascade", v), 32'(casc_pin()), 32'(e[0]));
    end

    // R7: downward exit appears on side_a for one clock
    apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0); step();
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < ROWS - 1; k++) step();
    chk("R2 down reaches bit0", 32'(row_oe), 32'h01);
    step();
    chk("R7 down cascade high", 32'(side_a), 32'h1);
    chk("R7 register empty", 32'(row_oe), 32'h0);
    step();
    chk("R7 down cascade falls", 32'(side_a), 32'h0);

    // R8: start while token in exit stage
    apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0); step();
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < ROWS - 1; k++) step();
    chk("R2 up reaches top", 32'(row_oe), 32'h80);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0); step();
    chk("R8 restart row_oe", 32'(row_oe), 32'h01);
    chk("R8 cascade cleared", 32'(side_b), 32'h0);

    // R2: reversal mid-walk
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0); step();
    chk("R2 before reversal", 32'(row_oe), 32'h02);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0); step();
    chk("R2 after reversal", 32'(row_oe), 32'h01);

    // R9: asynchronous clear and synchronised release
    apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0); step();
    #2 rst_n = 1'b0;
    #1 chk("R9 async clear", 32'(row_oe), 32'h0);
    step();
    rst_n = 1'b1;
    step();
    chk("R9 held 1st edge", 32'(row_oe), 32'h0);
    step();
    chk("R9 held 2nd edge", 32'(row_oe), 32'h0);
    step();
    chk("R9 active 3rd edge", 32'(row_oe), 32'h01);

    finish_run();
  end
endmodule